// File: doc/BRIEF.md
# Two-Channel External Interrupt Controller

This block turns two asynchronous external pins into interrupt requests for a processor core. Each pin is brought into the clock domain through a flop synchronizer. It is then watched for a condition picked per channel: low level, any change, falling edge or rising edge. In the edge-based modes a detected event latches a pending bit. In level mode no bit latches, and the request tracks the synchronized pin for as long as it stays low.

Software reaches three byte-wide registers over a simple write-strobe bus with combinational read data: an enable register, a pending register and a sense-select register. Pending bits are cleared by writing one to them, or by the core's acknowledge when it takes that channel's vector. Enabled, pending or level-active channels are gated by a global enable input and reduced to a single request with a vector index. Channel 0 wins when both compete.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the enable (address 0), pending (address 1) and sense (address 2) registers all read 0x00, and the request output is low.
- R2: In the enable and pending registers only bits [1:0] exist, bit 0 for channel 0 and bit 1 for channel 1. In the sense register only bits [3:0] exist. All other bits read as zero and ignore writes.
- R3: A channel drives the request only when its enable bit is one and the global enable input is one.
- R4: The sense field is bits [1:0] for channel 0 and [3:2] for channel 1, coded 00 low level, 01 any change, 10 falling edge, 11 rising edge. In an edge mode, each qualifying pin transition sets the pending bit once. The bit reads one three clock edges after the pin changes. Transitions of the other polarity do not set it.
- R5: Writing one to a pending bit clears it. Writing zero leaves it unchanged.
- R6: An acknowledge while the request is high clears only the pending bit of the channel shown on the vector index.
- R7: While a channel is in level mode, its pending bit reads zero, including in the cycle after the mode is written. Its request follows the synchronized pin and is high while the pin is low. It drops two clock edges after the pin returns high.
- R8: When both channels are active, the vector index is 0. Otherwise it names the single active channel.
- R9: If a hardware event and a write-one-to-clear hit the same pending bit on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 2 | Asynchronous external interrupt pins, bit n for channel n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 enable, 1 pending, 2 sense |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Vector taken by the core |
| irq_req_o | output | 1 | Combined interrupt request |
| irq_vec_o | output | 1 | Index of the winning channel |

## Verification
Read data, request and vector index are combinational. They are sampled on the falling edge of the same cycle in which address, enables or flags settle. Register writes and acknowledges show on the read port in the cycle after the strobe. A pin edge shows in the pending register three rising edges after the pin moves, and a level request two edges after. The bench queues each expectation stamped with the cycle in which it is due. It reads the pending bit at one, two and three cycles after a pin change, so an extra or missing synchronizer stage is caught. The set-versus-clear collision is driven by placing the write strobe in exactly the cycle whose closing edge latches the event.

// File: rtl/extint_pkg.sv
// Package: shared constants and types for the external interrupt controller.
// Assumes a byte-wide register bus with at most four channels, so that the
// sense fields of all channels fit in one register.
package extint_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int SENSE_W    = 2;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PENDING = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SENSE   = 2'd2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/extint_detect.sv
// Module: per-channel pin synchronizer and condition detector.
// Passes the asynchronous pin through SYNC_STAGES flops. It keeps one more
// flop holding the previous synchronized value. It flags a one-cycle event
// for the selected edge type and a level indication for low-level mode.
// Assumes SYNC_STAGES >= 2 and that pins idle at IDLE_LEVEL.
module extint_detect
    import extint_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_e sense_i,
    output logic   event_o,
    output logic   level_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   sync_w;

    assign sync_w = chain_q[SYNC_STAGES-1];

    // Shift the pin through the synchronizer and remember the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {SYNC_STAGES{IDLE_LEVEL}};
            prev_q  <= IDLE_LEVEL;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
            prev_q  <= sync_w;
        end
    end

    // Decode the selected sense mode into an edge event or a level indication.
    always_comb begin
        event_o = 1'b0;
        level_o = 1'b0;
        unique case (sense_i)
            SENSE_LOW:  level_o = ~sync_w;
            SENSE_ANY:  event_o = sync_w ^ prev_q;
            SENSE_FALL: event_o = prev_q & ~sync_w;
            SENSE_RISE: event_o = sync_w & ~prev_q;
            default:    event_o = 1'b0;
        endcase
    end

    // R4: an edge event never fires while the settled pin value is unchanged.
    assert_event_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (sync_w != prev_q));

    // R7: level mode never produces an edge event.
    assert_level_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SENSE_LOW) |-> !event_o);
endmodule

// File: rtl/extint_regs.sv
// Module: enable, pending and sense registers with a combinational read port.
// Pending bits set on hardware events. They clear on a one written to them or
// on an acknowledge clear from the arbiter, and the event wins a collision.
// A channel whose sense value (current or being written) is low level holds
// its pending bit at zero. Reserved bits are never stored.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    input  logic [NUM_CH-1:0]           set_i,
    input  logic [NUM_CH-1:0]           ack_clr_i,
    output logic [NUM_CH-1:0]           enable_o,
    output logic [NUM_CH-1:0]           pending_o,
    output logic [NUM_CH*SENSE_W-1:0]   sense_o
);
    localparam int SENSE_BITS = NUM_CH * SENSE_W;

    logic [NUM_CH-1:0]     enable_q;
    logic [NUM_CH-1:0]     pending_q;
    logic [SENSE_BITS-1:0] sense_q;
    logic [SENSE_BITS-1:0] sense_next;
    logic [NUM_CH-1:0]     w1c_w;
    logic [NUM_CH-1:0]     level_mode_w;
    logic [NUM_CH-1:0]     pending_next;

    // Decode the write strobe into the next sense value and the clear mask.
    always_comb begin
        sense_next = sense_q;
        w1c_w      = '0;
        if (wr_i && addr_i == ADDR_SENSE)   sense_next = wdata_i[SENSE_BITS-1:0];
        if (wr_i && addr_i == ADDR_PENDING) w1c_w      = wdata_i[NUM_CH-1:0];
    end

    // Per channel: pending bit forced low in level mode, else set beats clear.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
        assign level_mode_w[c] =
            (sense_q[c*SENSE_W +: SENSE_W]    == SENSE_LOW) ||
            (sense_next[c*SENSE_W +: SENSE_W] == SENSE_LOW);
        assign pending_next[c] = level_mode_w[c] ? 1'b0 :
            (set_i[c] | (pending_q[c] & ~w1c_w[c] & ~ack_clr_i[c]));

        // R7: a channel in level mode shows a zero pending bit on the next cycle.
        assert_level_pending_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_q[c*SENSE_W +: SENSE_W] == SENSE_LOW) |=> !pending_q[c]);

        // R5: a one written with no competing event leaves the bit clear.
        assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == ADDR_PENDING && wdata_i[c] && !set_i[c]) |=> !pending_q[c]);

        // R9: an event in an edge mode is always latched, even against a clear.
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[c] && !level_mode_w[c]) |=> pending_q[c]);
    end

    // Register updates for enable, sense and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q  <= '0;
            pending_q <= '0;
            sense_q   <= '0;
        end else begin
            if (wr_i && addr_i == ADDR_ENABLE) enable_q <= wdata_i[NUM_CH-1:0];
            sense_q   <= sense_next;
            pending_q <= pending_next;
        end
    end

    // Combinational read mux; unimplemented bits and addresses return zero.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_ENABLE:  rdata_o[NUM_CH-1:0]     = enable_q;
            ADDR_PENDING: rdata_o[NUM_CH-1:0]     = pending_q;
            ADDR_SENSE:   rdata_o[SENSE_BITS-1:0] = sense_q;
            default:      rdata_o                 = '0;
        endcase
    end

    assign enable_o  = enable_q;
    assign pending_o = pending_q;
    assign sense_o   = sense_q;

    // R2: reserved bits of the enable and pending registers read as zero.
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_ENABLE || addr_i == ADDR_PENDING) |-> (rdata_o[DATA_W-1:NUM_CH] == '0));
endmodule

// File: rtl/extint_arbiter.sv
// Module: gate, prioritize and acknowledge the channel requests.
// A channel is active when pending or level-asserted, enabled and globally
// enabled. The lowest index wins. An acknowledge while requesting returns a
// one-hot clear for the winner only.
module extint_arbiter #(
    parameter int NUM_CH = 2,
    parameter int VEC_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending_i,
    input  logic [NUM_CH-1:0] level_i,
    input  logic [NUM_CH-1:0] enable_i,
    input  logic              gie_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [NUM_CH-1:0] ack_clr_o
);
    logic [NUM_CH-1:0] active_w;

    assign active_w = (pending_i | level_i) & enable_i & {NUM_CH{gie_i}};
    assign req_o    = |active_w;

    // Priority encode: scan from the top so the lowest active index remains.
    always_comb begin
        vec_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (active_w[i]) vec_o = VEC_W'(i);
        end
    end

    // Turn an acknowledge into a clear for the winning channel.
    always_comb begin
        ack_clr_o = '0;
        if (ack_i && req_o) ack_clr_o[vec_o] = 1'b1;
    end

    // R3: no request while the global enable is low.
    assert_gated_by_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> gie_i);

    // R8: channel 0 active always wins the vector.
    assert_ch0_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i[0] || level_i[0]) && enable_i[0] && gie_i |-> (vec_o == '0));

    // R6: an acknowledge clears at most one channel.
    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: top of the external interrupt controller.
// Instantiates one detector per channel, the register block and the arbiter.
// Assumes the core holds irq_ack_i for one cycle when it takes the vector.
module ext_irq_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    pin_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic                 gie_i,
    input  logic                 irq_ack_i,
    output logic                 irq_req_o,
    output logic [VEC_W-1:0]     irq_vec_o
);
    logic [NUM_CH-1:0]         event_w;
    logic [NUM_CH-1:0]         level_w;
    logic [NUM_CH-1:0]         enable_w;
    logic [NUM_CH-1:0]         pending_w;
    logic [NUM_CH-1:0]         ack_clr_w;
    logic [NUM_CH*SENSE_W-1:0] sense_w;

    // One synchronizer and detector per external pin.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        extint_detect #(
            .SYNC_STAGES (SYNC_STAGES),
            .IDLE_LEVEL  (1'b1)
        ) i_detect (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[c]),
            .sense_i (sense_e'(sense_w[c*SENSE_W +: SENSE_W])),
            .event_o (event_w[c]),
            .level_o (level_w[c])
        );
    end

    extint_regs #(
        .NUM_CH (NUM_CH)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .rdata_o   (bus_rdata_o),
        .set_i     (event_w),
        .ack_clr_i (ack_clr_w),
        .enable_o  (enable_w),
        .pending_o (pending_w),
        .sense_o   (sense_w)
    );

    extint_arbiter #(
        .NUM_CH (NUM_CH),
        .VEC_W  (VEC_W)
    ) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending_w),
        .level_i   (level_w),
        .enable_i  (enable_w),
        .gie_i     (gie_i),
        .ack_i     (irq_ack_i),
        .req_o     (irq_req_o),
        .vec_o     (irq_vec_o),
        .ack_clr_o (ack_clr_w)
    );

    // R6: an acknowledge clears the pending bit of the channel that was shown.
    assert_ack_clears_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o && !event_w[irq_vec_o]) |=> !pending_w[$past(irq_vec_o)]);
endmodule

// File: tb/test_ext_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected observations stamped with the
// cycle they are due; a falling-edge monitor pops and compares them.
module test_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int          due;
        logic [15:0] exp;
        logic [15:0] msk;
        string       tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin = 2'b11;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0;
    logic       ack = 1'b0;
    logic       irq_req;
    logic [0:0] irq_vec;

    int       cyc = 0;
    int       checks = 0;
    int       failures = 0;
    bit       done = 1'b0;
    sb_item_t sb[$];

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .gie_i       (gie),
        .irq_ack_i   (ack),
        .irq_req_o   (irq_req),
        .irq_vec_o   (irq_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        logic [15:0] obs;
        obs = {bus_rdata, 6'b0, irq_vec[0], irq_req};
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            checks++;
            if (sb[0].due != cyc || ((obs ^ sb[0].exp) & sb[0].msk) != 16'h0) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", sb[0].tag, obs & sb[0].msk, sb[0].exp);
            end
            void'(sb.pop_front());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        ack    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        bus_addr = a;
        it.due = cyc; it.exp = {e, 8'h00}; it.msk = 16'hFF00; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic exp_irq(input logic r, input logic v, input string tag);
        sb_item_t it;
        it.due = cyc; it.exp = {14'h0, v, r}; it.msk = r ? 16'h0003 : 16'h0001; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        exp_rd(2'd0, 8'h00, "R1 enable reset");
        exp_rd(2'd1, 8'h00, "R1 pending reset");
        exp_rd(2'd2, 8'h00, "R1 sense reset");
        exp_irq(1'b0, 1'b0, "R1 request reset");
        // R2: reserved bits
        wr(2'd0, 8'hFF);
        exp_rd(2'd0, 8'h03, "R2 enable reserved");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFE);
        exp_rd(2'd2, 8'h0E, "R2 sense reserved");
        // R4: ch0 falling edge, latency three edges
        pin[0] = 1'b0;
        exp_rd(2'd1, 8'h00, "R4 fall +0");
        exp_rd(2'd1, 8'h00, "R4 fall +1");
        exp_rd(2'd1, 8'h00, "R4 fall +2");
        exp_rd(2'd1, 8'h01, "R4 fall +3");
        // R5: write one clears
        wr(2'd1, 8'h01);
        exp_rd(2'd1, 8'h00, "R5 w1c ch0");
        // R4: rising ignored in falling mode, held low sets once
        pin[0] = 1'b1; idle(4);
        exp_rd(2'd1, 8'h00, "R4 rise ignored in fall mode");
        pin[0] = 1'b0; idle(4);
        wr(2'd1, 8'h01); idle(3);
        exp_rd(2'd1, 8'h00, "R4 one set per edge");
        // R4: ch1 rising edge
        pin[1] = 1'b0; idle(4);
        exp_rd(2'd1, 8'h00, "R4 fall ignored in rise mode");
        pin[1] = 1'b1; idle(4);
        exp_rd(2'd1, 8'h02, "R4 ch1 rise");
        // R5: writing zero has no effect
        wr(2'd1, 8'h00);
        exp_rd(2'd1, 8'h02, "R5 write zero keeps");
        // R3: gating by enable and global enable
        exp_irq(1'b0, 1'b0, "R3 masked");
        wr(2'd0, 8'h02);
        exp_irq(1'b0, 1'b0, "R3 gie low");
        gie = 1'b1;
        exp_irq(1'b1, 1'b1, "R3 ch1 request");
        wr(2'd0, 8'h00);
        exp_irq(1'b0, 1'b0, "R3 disabled again");
        // R8: both pending, ch0 wins
        pin[0] = 1'b1; idle(4);
        pin[0] = 1'b0; idle(4);
        exp_rd(2'd1, 8'h03, "R8 both pending");
        wr(2'd0, 8'h03);
        exp_irq(1'b1, 1'b0, "R8 ch0 priority");
        // R6: acknowledge clears the winner only
        ack = 1'b1; tick();
        exp_rd(2'd1, 8'h02, "R6 ack clears ch0");
        exp_irq(1'b1, 1'b1, "R6 ch1 now wins");
        ack = 1'b1; tick();
        exp_rd(2'd1, 8'h00, "R6 ack clears ch1");
        exp_irq(1'b0, 1'b0, "R6 no request left");
        // R9: event and clear on the same edge
        pin[1] = 1'b0; idle(4);
        pin[1] = 1'b1;
        tick(); tick();
        wr(2'd1, 8'h02);
        exp_rd(2'd1, 8'h02, "R9 set beats clear");
        wr(2'd1, 8'h02);
        exp_rd(2'd1, 8'h00, "R9 later clear works");
        // R7: level mode on ch0
        pin[0] = 1'b1; idle(4);
        pin[0] = 1'b0; idle(4);
        exp_rd(2'd1, 8'h01, "R7 ch0 pending before level");
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h0C);
        exp_rd(2'd1, 8'h00, "R7 pending zero in level mode");
        pin[0] = 1'b1;
        exp_irq(1'b1, 1'b0, "R7 level req +0");
        exp_irq(1'b1, 1'b0, "R7 level req +1");
        exp_irq(1'b0, 1'b0, "R7 level req drops +2");
        pin[0] = 1'b0; idle(2);
        exp_irq(1'b1, 1'b0, "R7 level req again");
        exp_rd(2'd1, 8'h00, "R7 pending stays zero");
        // R4: any-change mode on ch0
        wr(2'd2, 8'h0D);
        pin[0] = 1'b1; idle(4);
        exp_rd(2'd1, 8'h01, "R4 any change rise");
        wr(2'd1, 8'h01);
        pin[0] = 1'b0; idle(4);
        exp_rd(2'd1, 8'h01, "R4 any change fall");
        idle(2);
        if (sb.size() != 0) begin
            checks++; failures++;
            $display("FAIL R1-scoreboard actual=%0d expected=0 pending items", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule